// File: doc/BRIEF.md
# Shared-DRAM Strobe Sequencer

This block times every access to a dynamic memory that is shared by a video fetch engine and an 8-bit CPU. A free-running eight-bit twisted-ring (Johnson) phase register advances on each master clock and walks through sixteen states. One full ring is one memory frame, which is four CPU clock periods. The row strobe, the CPU address window, the CPU clock and all column strobes are decoded from that phase word alone. Sync, blanking and border timing do not affect them.

Each frame starts with a video slot. One row strobe is followed by two column strobes, and the byte-select bit toggles between them, so two neighbouring bytes are read under one row. The slot ends with a CPU slot. In that slot the CPU address drives the memory and a column strobe is issued only for a real read or write. A memory request that is neither a read nor a write, such as the CPU's own refresh cycle, gets no column strobe. The low address bits above bit 0 form the row. A linear video scan therefore strobes every row in a short time, and the memory is refreshed without a separate counter.

Top module: `dram_phase_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the phase register loads its all-ones state. In the cycle that follows, `ras_n`, `cas_n`, `we_n`, `cpu_sel_n` and `wait_n` are high and `cpu_clk` is low.
- R2: Let slot s (0..15) be the number of clock edges since reset release, modulo 16. `ras_n` is high in slots 0, 1, 10 and 11 and low in every other slot. This pattern holds whatever the CPU inputs do.
- R3: `cpu_sel_n` is low exactly in slots 10 to 15 and high in slots 0 to 9.
- R4: `cpu_clk` is high in slots whose number modulo 4 is 2 or 3, and low otherwise.
- R5: In every frame, `cas_n` goes low in slot 5 and in slot 7 and is high in slot 6.
- R6: In slots 3 to 8 and 13 to 15, `dram_addr` is the column half: address bits 15..9 above address bit 0. In all other slots it is the row half: address bits 8..1. The address is the CPU address in slots 10 to 15. In other slots it is the video word address, extended by a byte bit that is 0 before slot 6 and 1 from slot 6 on.
- R7: `cas_n` is low in slot 14 only if a CPU access was presented in slot 13. A CPU access is `mreq_n` low, `rfsh_n` high, and either `rd_n` or `wr_n` low.
- R8: `we_n` is low only in slot 14, and only if a CPU write (`wr_n` low within an access) was presented in slot 13.
- R9: A memory request with `rfsh_n` low, or with neither `rd_n` nor `wr_n` low, is ignored. It gives no column strobe in slot 14 and no write strobe.
- R10: `wait_n` is low while a CPU access is presented in slots 0 to 9. It is high in slots 10 to 15 and whenever no access is presented.
- R11: If the video word address advances by one per frame, every one of the 256 row codes is driven under a falling `ras_n` within 2 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, four times the CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mreq_n | input | 1 | CPU memory request, active low |
| rd_n | input | 1 | CPU read, active low |
| wr_n | input | 1 | CPU write, active low |
| rfsh_n | input | 1 | CPU refresh cycle flag, active low |
| vid_addr | input | 15 | Video word address (address bits 15..1) |
| cpu_addr | input | 16 | CPU byte address |
| ras_n | output | 1 | Registered row strobe, active low |
| cas_n | output | 1 | Registered column strobe, active low |
| we_n | output | 1 | Registered write strobe, active low |
| cpu_sel_n | output | 1 | Low while the CPU address drives the memory |
| wait_n | output | 1 | Low to stall the CPU until its window |
| cpu_clk | output | 1 | CPU clock decoded from the phase |
| dram_addr | output | 8 | Multiplexed row or column address |

## Verification
The assertions assume that `rd_n` and `wr_n` are never low together. They also assume that the CPU control lines stay constant across each frame, which is what the wait request is meant to produce. The stimulus picks a new CPU mode (idle, read, write, refresh, or a bare request) and a new address only at the start of slot 0, and it never asserts both read and write. The video address steps once per frame, so the row-coverage claim is checked on a realistic scan.

// File: rtl/dram_seq_pkg.sv
// Shared types and the ring step for the DRAM strobe sequencer.
// Assumes an eight-bit twisted ring; all decodes elsewhere rely on that width.
package dram_seq_pkg;
    localparam int PH_W = 8;
    typedef logic [PH_W-1:0] phase_t;
    localparam phase_t PH_RESET = '1;

    // One step of the twisted ring: shift up, feed back the inverted top bit.
    function automatic phase_t phase_step(input phase_t p);
        return {p[PH_W-2:0], ~p[PH_W-1]};
    endfunction
endpackage

// File: rtl/dram_phase_gen.sv
// Phase sequencer: a 16-state twisted ring clocked by the master clock,
// plus the CPU clock decoded from it. Assumes an eight-bit phase word.
module dram_phase_gen
    import dram_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   cpu_clk
);
    phase_t lo_run;
    phase_t hi_run;

    // Advance the ring every master clock; reset parks it at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_RESET;
        else        phase <= phase_step(phase);
    end

    // CPU clock: parity of the odd phase bits gives a period of four states.
    assign cpu_clk = phase[7] ^ phase[5] ^ phase[3] ^ phase[1];

    // Shape checks: a legal ring word is one run of ones at the bottom or at the top.
    assign lo_run = phase & (phase + 8'd1);
    assign hi_run = ~phase & (~phase + 8'd1);

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_run == '0) || (hi_run == '0)); // R2
endmodule

// File: rtl/dram_strobe_gen.sv
// Strobe decoder: row strobe, column strobe, write strobe, CPU window and
// wait request, all decoded from the phase word. The strobes are registered.
// Assumes rd_n and wr_n are never low together and that the CPU control lines
// stay constant within a frame.
module dram_strobe_gen
    import dram_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   mreq_n,
    input  logic   rd_n,
    input  logic   wr_n,
    input  logic   rfsh_n,
    output logic   ras_n,
    output logic   cas_n,
    output logic   we_n,
    output logic   cpu_sel_n,
    output logic   wait_n,
    output logic   col_phase,
    output logic   vid_byte
);
    logic ras_lvl;
    logic cpu_win;
    logic vid_cas_a;
    logic vid_cas_b;
    logic cpu_cas_slot;
    logic cpu_req;
    logic cpu_wr_req;

    // Row strobe level: high for four ring states, low for the other twelve.
    assign ras_lvl = phase[0] & (~phase[2] | phase[6]);

    // CPU window: six consecutive ring states at the end of the frame.
    assign cpu_win   = phase[1] & ~phase[7];
    assign cpu_sel_n = ~cpu_win;

    // Single-state decodes at the edges of the runs of ones.
    assign vid_cas_a    = phase[4] & ~phase[3];
    assign vid_cas_b    = phase[6] & ~phase[5];
    assign cpu_cas_slot = phase[4] & ~phase[5];

    // Real CPU access: a request with a read or a write, and not a refresh cycle.
    assign cpu_req    = ~mreq_n & rfsh_n & (~rd_n | ~wr_n);
    assign cpu_wr_req = cpu_req & ~wr_n;

    // Column half of the address while either slot's columns are strobed.
    assign col_phase = (~phase[2] & ~phase[0]) | (phase[4] & ~phase[7]);
    assign vid_byte  = ~phase[5];

    // Hold the CPU until its window while an access is pending.
    assign wait_n = ~(cpu_req & ~cpu_win);

    // Register the strobes so the pins change one clock after the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            ras_n <= ras_lvl;
            cas_n <= ~(vid_cas_a | vid_cas_b | (cpu_cas_slot & cpu_req));
            we_n  <= ~(cpu_cas_slot & cpu_wr_req);
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R5
    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cpu_sel_n && !cas_n)); // R8
    AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_n && !cpu_sel_n) |=> ((cpu_sel_n || cas_n) && we_n)); // R9
    AST_SEL_OPENS_HIGH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_sel_n) |-> ras_n); // R3
    AST_WAIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> cpu_sel_n); // R10
endmodule

// File: rtl/dram_addr_mux.sv
// Address multiplexer: picks the video or the CPU source, then the row half
// (bits ROW_W..1) or the column half (upper bits above bit 0).
// Assumes ADDR_W == 2*ROW_W, so both halves have the same width.
module dram_addr_mux #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 8
) (
    input  logic              cpu_sel_n,
    input  logic              col_phase,
    input  logic              vid_byte,
    input  logic [ADDR_W-1:1] vid_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ROW_W-1:0]  dram_addr
);
    logic [ADDR_W-1:0] src;

    // Source select: video word plus byte bit, or the full CPU byte address.
    assign src = cpu_sel_n ? {vid_addr, vid_byte} : cpu_addr;

    // Half select: the row takes the bits just above bit 0, and bit 0 goes to the column.
    assign dram_addr = col_phase ? {src[ADDR_W-1:ROW_W+1], src[0]} : src[ROW_W:1];
endmodule

// File: rtl/dram_phase_ctrl.sv
// Top: the shared-DRAM strobe sequencer. It ties the phase ring, the strobe
// decoder and the address multiplexer together. Assumes one master clock at
// four times the CPU clock and a synchronous active-low reset.
module dram_phase_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rfsh_n,
    input  logic [ADDR_W-1:1] vid_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cpu_sel_n,
    output logic              wait_n,
    output logic              cpu_clk,
    output logic [ROW_W-1:0]  dram_addr
);
    phase_t phase;
    logic   col_phase;
    logic   vid_byte;

    dram_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .cpu_clk (cpu_clk)
    );

    dram_strobe_gen u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .mreq_n    (mreq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rfsh_n    (rfsh_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cpu_sel_n (cpu_sel_n),
        .wait_n    (wait_n),
        .col_phase (col_phase),
        .vid_byte  (vid_byte)
    );

    dram_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_mux (
        .cpu_sel_n (cpu_sel_n),
        .col_phase (col_phase),
        .vid_byte  (vid_byte),
        .vid_addr  (vid_addr),
        .cpu_addr  (cpu_addr),
        .dram_addr (dram_addr)
    );
endmodule

// File: tb/dram_phase_ctrl_bench.sv
module dram_phase_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 256;
    localparam int FRAMES     = 2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mreq_n, rd_n, wr_n, rfsh_n;
    logic [15:1] vid_addr;
    logic [15:0] cpu_addr;
    logic        ras_n, cas_n, we_n, cpu_sel_n, wait_n, cpu_clk;
    logic [7:0]  dram_addr;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_phase_ctrl u_dram_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .rfsh_n(rfsh_n), .vid_addr(vid_addr), .cpu_addr(cpu_addr),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cpu_sel_n(cpu_sel_n),
        .wait_n(wait_n), .cpu_clk(cpu_clk), .dram_addr(dram_addr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Expected values, written from the requirements by slot number.
    function automatic logic e_ras(input int k);
        return (k == 0 || k == 1 || k == 10 || k == 11);
    endfunction
    function automatic logic e_sel(input int k);
        return !(k >= 10);
    endfunction
    function automatic logic e_clk(input int k);
        return (k % 4) >= 2;
    endfunction
    function automatic logic e_cas(input int k, input logic req);
        return !(k == 5 || k == 7 || (k == 14 && req));
    endfunction
    function automatic logic e_we(input int k, input logic wrq);
        return !(k == 14 && wrq);
    endfunction
    function automatic logic e_wait(input int k, input logic req);
        return !(req && k <= 9);
    endfunction
    function automatic logic [7:0] e_addr(input int k, input logic [15:1] va, input logic [15:0] ca);
        logic [15:0] full;
        logic        col;
        full = (k >= 10) ? ca : {va, (k >= 6) ? 1'b1 : 1'b0};
        col  = (k >= 3 && k <= 8) || (k >= 13);
        return col ? {full[15:9], full[0]} : full[8:1];
    endfunction

    // Drive one CPU mode: 0 idle, 1 read, 2 write, 3 refresh, 4 bare request.
    task automatic drive_mode(input int m);
        mreq_n = (m == 0);
        rd_n   = !(m == 1);
        wr_n   = !(m == 2);
        rfsh_n = !(m == 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int k;
        int mode;
        int frame;
        logic req, wrq, prev_ras;
        logic [NROWS-1:0] seen;
        int covered;

        void'($urandom(32'd20240314));
        rst_n    = 1'b0;
        drive_mode(0);
        vid_addr = 15'h1234;
        cpu_addr = 16'h0000;
        seen     = '0;

        // R1: reset state, sampled while reset is held
        repeat (3) begin
            @(negedge clk);
            chk("R1 ras_n", {15'd0, ras_n}, 16'd1);
            chk("R1 cas_n", {15'd0, cas_n}, 16'd1);
            chk("R1 we_n", {15'd0, we_n}, 16'd1);
            chk("R1 cpu_sel_n", {15'd0, cpu_sel_n}, 16'd1);
            chk("R1 wait_n", {15'd0, wait_n}, 16'd1);
            chk("R1 cpu_clk", {15'd0, cpu_clk}, 16'd0);
        end
        rst_n    = 1'b1;
        k        = 0;
        mode     = 0;
        frame    = 0;
        prev_ras = 1'b1;

        while (frame < FRAMES) begin
            @(posedge clk);
            k = (k + 1) % 16;
            #1;
            if (k == 0) begin
                frame++;
                vid_addr = vid_addr + 15'd1;
                // Directed frames first, then random modes and addresses
                if (frame <= 5) begin
                    mode     = frame - 1;
                    cpu_addr = (frame == 2) ? 16'hFFFF : 16'hA5C3 ^ 16'(frame);
                end else begin
                    mode     = $urandom_range(4, 0);
                    cpu_addr = 16'($urandom);
                end
                drive_mode(mode);
            end
            req = (mode == 1 || mode == 2);
            wrq = (mode == 2);
            @(negedge clk);
            chk("R2 ras_n", {15'd0, ras_n}, {15'd0, e_ras(k)});
            chk("R3 cpu_sel_n", {15'd0, cpu_sel_n}, {15'd0, e_sel(k)});
            chk("R4 cpu_clk", {15'd0, cpu_clk}, {15'd0, e_clk(k)});
            chk("R6 dram_addr", {8'd0, dram_addr}, {8'd0, e_addr(k, vid_addr, cpu_addr)});
            chk("R10 wait_n", {15'd0, wait_n}, {15'd0, e_wait(k, req)});
            if (k == 5 || k == 6 || k == 7)
                chk("R5 cas_n", {15'd0, cas_n}, {15'd0, e_cas(k, req)});
            else if (mode == 3 || mode == 4)
                chk("R9 cas_n", {15'd0, cas_n}, {15'd0, e_cas(k, 1'b0)});
            else
                chk("R7 cas_n", {15'd0, cas_n}, {15'd0, e_cas(k, req)});
            if (mode == 3 || mode == 4)
                chk("R9 we_n", {15'd0, we_n}, 16'd1);
            else
                chk("R8 we_n", {15'd0, we_n}, {15'd0, e_we(k, wrq)});
            // R11: record rows strobed by the video slot's falling row strobe
            if (prev_ras && !ras_n && k == 2)
                seen[dram_addr] = 1'b1;
            prev_ras = ras_n;
        end

        covered = $countones(seen);
        chk("R11 rows strobed", 16'(covered), 16'(NROWS));
        finish_run();
    end
endmodule